// File: doc/BRIEF.md
# Two-Channel Instruction Breakpoint with Resume-PC Capture

This block watches the commit stage of a simple in-order pipeline that uses delayed branches. Every cycle the pipeline may present one instruction slot: its address, whether it is a delayed branch (with outcome and target), whether it sits in a delay slot, whether it raised an exception, whether it was squashed, and its operand access address. Each of the two channels holds a programmed address, an enable bit and a mode. A channel can stop before an instruction executes, after it completes, or when a completed instruction accesses a matching operand address.

On a hit the block sets that channel's sticky match flag. It then pulses a break request and presents the PC that the handler must save. For a pre-execution hit it also asserts a same-cycle suppress signal, so that the pipeline drops the matching instruction. After a post-execution hit on a delayed branch, the request waits until the delay slot has committed. Once a request is issued, further matches are ignored until the handler acknowledges it. Software clears flags by writing zeros.

Top module: `dbg_break_unit`

## Requirements
- R1: A pre-execution hit (mode 2'b01, cm_pc equal to the channel address) on a valid, unsquashed slot asserts brk_suppress in the same cycle. The channel flag is set even if cm_exc is high (a fetch-side fault). In the next cycle brk_req pulses with brk_pc equal to the matching cm_pc.
- R2: A post-execution hit (mode 2'b10) on a completing slot (cm_exc low) that is neither a delayed branch nor a delay slot sets the flag. The next cycle pulses brk_req with brk_pc = cm_pc + INSN_BYTES.
- R3: A post-execution hit on a delayed branch (cm_dbranch) sets the flag when the branch commits. No request is made until the delay slot commits. The cycle after that, brk_req pulses with brk_pc equal to cm_target if the branch was taken, or the branch address + 2*INSN_BYTES if it was not.
- R4: A post-execution or operand hit on a delay-slot instruction (cm_dslot) reports the outcome of the preceding branch as brk_pc: the target if taken, otherwise cm_pc + INSN_BYTES.
- R5: An operand hit (mode 2'b11) requires cm_opacc high and cm_opaddr equal to the channel address. It sets the flag and requests a break only on completion, with the same brk_pc rule as R2. With cm_opacc low, no operand hit occurs.
- R6: A squashed slot sets no flag in any mode. A slot with cm_exc high sets no post-execution or operand flag and raises no request for those modes.
- R7: An operand hit with cm_multi high sets the flag even when cm_exc is high. It raises no request in that case.
- R8: From the cycle a request is decided until brk_ack, no slot sets a flag, asserts brk_suppress or raises a request.
- R9: When any channel takes a pre-execution hit, the instruction is suppressed and another channel's post-execution or operand match on it sets no flag. Two pre-execution hits on the same slot set both flags and give one request.
- R10: match_flags are sticky. A flag_we cycle clears each flag whose flag_wdata bit is 0 and keeps each flag whose bit is 1. A flag set in that same cycle wins.
- R11: A channel with its enable bit low, or with mode 2'b00, never hits. Channel 0 uses ch_en[0], ch_mode[1:0] and ch_addr[AW-1:0].
- R12: Under reset, match_flags are 0, and brk_req and brk_suppress are low.
- R13: brk_req is high for exactly one cycle per break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_en | input | NCH | Per-channel enable |
| ch_mode | input | 2*NCH | Per-channel mode: 00 off, 01 pre, 10 post, 11 operand |
| ch_addr | input | NCH*AW | Per-channel compare address |
| cm_valid | input | 1 | A slot is presented this cycle |
| cm_squash | input | 1 | Slot was skipped (taken-branch shadow or after an exception) |
| cm_pc | input | AW | Slot instruction address |
| cm_exc | input | 1 | Slot raised an exception and does not complete |
| cm_dbranch | input | 1 | Slot is a delayed branch |
| cm_dslot | input | 1 | Slot is a delay-slot instruction |
| cm_taken | input | 1 | Branch outcome (valid with cm_dbranch) |
| cm_target | input | AW | Branch target (valid with cm_dbranch) |
| cm_opacc | input | 1 | Slot performs an operand access |
| cm_opaddr | input | AW | Operand address |
| cm_multi | input | 1 | Slot makes more than one operand access |
| flag_we | input | 1 | Flag write strobe |
| flag_wdata | input | NCH | Flag write data (0 clears) |
| brk_ack | input | 1 | Handler acknowledge; re-arms requests |
| match_flags | output | NCH | Sticky per-channel match flags |
| brk_req | output | 1 | One-cycle break request |
| brk_pc | output | AW | PC to save for the handler |
| brk_suppress | output | 1 | Drop the current slot (pre-execution hit) |

## Verification
The bench builds the unit with AW=16, NCH=2 and INSN_BYTES=2. With the narrower address, each PC and target can be written as a readable 4-digit hex value, and a wrong step size shows up as an off-by-two or off-by-four address. With two channels, the bench can present cross-channel cases on a single slot: pre beside post, pre beside pre, and a pre hit that arrives while a request is still waiting for acknowledge. Delayed branches, taken and not taken, are run with the hit on the branch and with the hit in the delay slot.

// File: rtl/dbu_pkg.sv
package dbu_pkg;
  typedef enum logic [1:0] {
    BRK_OFF  = 2'b00,
    BRK_PRE  = 2'b01,
    BRK_POST = 2'b10,
    BRK_OPND = 2'b11
  } brk_mode_e;
endpackage

// File: rtl/dbu_chan_cmp.sv
module dbu_chan_cmp
  import dbu_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          en,
  input  logic [1:0]    mode,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] cm_pc,
  input  logic          cm_opacc,
  input  logic [AW-1:0] cm_opaddr,
  output logic          hit_pre,
  output logic          hit_post,
  output logic          hit_op
);
  logic ins_eq;
  logic opd_eq;

  always_comb begin
    ins_eq   = (cm_pc == addr);
    opd_eq   = cm_opacc && (cm_opaddr == addr);
    hit_pre  = en && (mode == BRK_PRE)  && ins_eq;
    hit_post = en && (mode == BRK_POST) && ins_eq;
    hit_op   = en && (mode == BRK_OPND) && opd_eq;
  end
endmodule

// File: rtl/dbu_resume_pc.sv
module dbu_resume_pc #(
  parameter int AW         = 32,
  parameter int INSN_BYTES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cm_valid,
  input  logic          cm_squash,
  input  logic [AW-1:0] cm_pc,
  input  logic          cm_dbranch,
  input  logic          cm_dslot,
  input  logic          cm_taken,
  input  logic [AW-1:0] cm_target,
  output logic [AW-1:0] resume_pc
);
  localparam logic [AW-1:0] STEP = AW'(INSN_BYTES);

  logic          taken_q, taken_d;
  logic [AW-1:0] tgt_q, tgt_d;
  logic          br_en;

  // Branch outcome is held until its delay slot commits.
  always_comb begin
    br_en   = cm_valid && !cm_squash && cm_dbranch;
    taken_d = taken_q;
    tgt_d   = tgt_q;
    if (br_en) begin
      taken_d = cm_taken;
      tgt_d   = cm_target;
    end
    if (cm_dslot && taken_q) resume_pc = tgt_q;
    else                     resume_pc = cm_pc + STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken_q <= 1'b0;
      tgt_q   <= '0;
    end else begin
      taken_q <= taken_d;
      tgt_q   <= tgt_d;
    end
  end
endmodule

// File: rtl/dbg_break_unit.sv
module dbg_break_unit #(
  parameter int AW         = 32,
  parameter int NCH        = 2,
  parameter int INSN_BYTES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    ch_en,
  input  logic [2*NCH-1:0]  ch_mode,
  input  logic [NCH*AW-1:0] ch_addr,
  input  logic              cm_valid,
  input  logic              cm_squash,
  input  logic [AW-1:0]     cm_pc,
  input  logic              cm_exc,
  input  logic              cm_dbranch,
  input  logic              cm_dslot,
  input  logic              cm_taken,
  input  logic [AW-1:0]     cm_target,
  input  logic              cm_opacc,
  input  logic [AW-1:0]     cm_opaddr,
  input  logic              cm_multi,
  input  logic              flag_we,
  input  logic [NCH-1:0]    flag_wdata,
  input  logic              brk_ack,
  output logic [NCH-1:0]    match_flags,
  output logic              brk_req,
  output logic [AW-1:0]     brk_pc,
  output logic              brk_suppress
);
  localparam logic [AW-1:0] STEP = AW'(INSN_BYTES);

  logic [NCH-1:0] hit_pre, hit_post, hit_op;
  logic [NCH-1:0] pre_v, post_v, multi_v, set_v;
  logic [NCH-1:0] flags_q, flags_d;
  logic           wait_q, wait_d;
  logic           defer_q, defer_d;
  logic           req_q, req_d;
  logic [AW-1:0]  pc_q, pc_d;
  logic [AW-1:0]  resume_pc;
  logic           gate, pre_any, done, post_any, req_now;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dbu_chan_cmp #(.AW(AW)) u_cmp (
      .en       (ch_en[i]),
      .mode     (ch_mode[2*i +: 2]),
      .addr     (ch_addr[AW*i +: AW]),
      .cm_pc    (cm_pc),
      .cm_opacc (cm_opacc),
      .cm_opaddr(cm_opaddr),
      .hit_pre  (hit_pre[i]),
      .hit_post (hit_post[i]),
      .hit_op   (hit_op[i])
    );
  end

  dbu_resume_pc #(.AW(AW), .INSN_BYTES(INSN_BYTES)) u_resume (
    .clk       (clk),
    .rst_n     (rst_n),
    .cm_valid  (cm_valid),
    .cm_squash (cm_squash),
    .cm_pc     (cm_pc),
    .cm_dbranch(cm_dbranch),
    .cm_dslot  (cm_dslot),
    .cm_taken  (cm_taken),
    .cm_target (cm_target),
    .resume_pc (resume_pc)
  );

  // Next-state logic
  always_comb begin
    gate     = cm_valid && !cm_squash && !wait_q;
    pre_v    = hit_pre & {NCH{gate}};
    pre_any  = |pre_v;
    done     = gate && !cm_exc && !pre_any;
    post_v   = (hit_post | hit_op) & {NCH{done}};
    multi_v  = hit_op & {NCH{gate && cm_multi && !pre_any}};
    set_v    = pre_v | post_v | multi_v;
    post_any = |post_v;
    req_now  = pre_any || (post_any && !cm_dbranch) || (defer_q && done);

    defer_d = defer_q;
    if (gate) defer_d = post_any && cm_dbranch;

    flags_d = flags_q;
    if (flag_we) flags_d = flags_d & flag_wdata;
    flags_d = flags_d | set_v;

    wait_d = wait_q;
    if (req_now)     wait_d = 1'b1;
    else if (brk_ack) wait_d = 1'b0;

    req_d = req_now;
    pc_d  = pc_q;
    if (req_now) pc_d = pre_any ? cm_pc : resume_pc;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      wait_q  <= 1'b0;
      defer_q <= 1'b0;
      req_q   <= 1'b0;
      pc_q    <= '0;
    end else begin
      flags_q <= flags_d;
      wait_q  <= wait_d;
      defer_q <= defer_d;
      req_q   <= req_d;
      pc_q    <= pc_d;
    end
  end

  assign match_flags  = flags_q;
  assign brk_req      = req_q;
  assign brk_pc       = pc_q;
  assign brk_suppress = pre_any;

  // Checks
  assert_pre_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
    brk_suppress |=> (brk_req && brk_pc == $past(cm_pc)));

  assert_post_resume_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_valid && !cm_squash && !wait_q && !cm_exc && !cm_dslot && !cm_dbranch
     && !brk_suppress && (|(hit_post | hit_op)))
    |=> (brk_req && brk_pc == $past(cm_pc) + STEP));

  assert_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_q && !brk_ack) |=> !brk_req);

  assert_single_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |=> !brk_req);

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(match_flags[i]) |-> $past(flag_we && !flag_wdata[i]));
    assert_no_squash_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(match_flags[i]) |-> $past(cm_valid && !cm_squash));
  end
endmodule

// File: tb/sim_dbg_break_unit.sv
module sim_dbg_break_unit;
  localparam int AW = 16;
  localparam int NCH = 2;
  localparam int NV = 14;

  typedef struct packed {
    logic [1:0]  en;
    logic [1:0]  m0;
    logic [1:0]  m1;
    logic [15:0] a0;
    logic [15:0] a1;
    logic [15:0] pc;
    logic        exc;
    logic        sq;
    logic        opacc;
    logic [15:0] opaddr;
    logic        multi;
    logic [1:0]  ef;
    logic        er;
    logic [15:0] epc;
    logic        es;
    logic [3:0]  rq;
  } vec_t;

  // en, m0, m1, a0, a1, pc, exc, sq, opacc, opaddr, multi, eflags, ereq, epc, esup, req
  localparam vec_t TBL [NV] = '{
    '{2'b11, 2'b01, 2'b00, 16'h0100, 16'h0200, 16'h0100, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 2'b01, 1'b1, 16'h0100, 1'b1, 4'd1}, // R1 pre
    '{2'b11, 2'b01, 2'b00, 16'h0100, 16'h0200, 16'h0100, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b0, 2'b01, 1'b1, 16'h0100, 1'b1, 4'd1}, // R1 pre with fetch fault
    '{2'b11, 2'b10, 2'b00, 16'h0100, 16'h0200, 16'h0100, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 2'b01, 1'b1, 16'h0102, 1'b0, 4'd2}, // R2 post
    '{2'b11, 2'b10, 2'b00, 16'h0100, 16'h0200, 16'h0100, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b0, 2'b00, 1'b0, 16'h0000, 1'b0, 4'd6}, // R6 post + exception
    '{2'b11, 2'b01, 2'b00, 16'h0100, 16'h0200, 16'h0100, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b0, 2'b00, 1'b0, 16'h0000, 1'b0, 4'd6}, // R6 squashed pre
    '{2'b11, 2'b00, 2'b11, 16'h0100, 16'h0300, 16'h0150, 1'b0, 1'b0, 1'b1, 16'h0300, 1'b0, 2'b10, 1'b1, 16'h0152, 1'b0, 4'd5}, // R5 operand
    '{2'b11, 2'b00, 2'b11, 16'h0100, 16'h0300, 16'h0150, 1'b0, 1'b0, 1'b0, 16'h0300, 1'b0, 2'b00, 1'b0, 16'h0000, 1'b0, 4'd5}, // R5 no access
    '{2'b11, 2'b00, 2'b11, 16'h0100, 16'h0300, 16'h0150, 1'b1, 1'b0, 1'b1, 16'h0300, 1'b1, 2'b10, 1'b0, 16'h0000, 1'b0, 4'd7}, // R7 multi + exc
    '{2'b11, 2'b00, 2'b11, 16'h0100, 16'h0300, 16'h0150, 1'b1, 1'b0, 1'b1, 16'h0300, 1'b0, 2'b00, 1'b0, 16'h0000, 1'b0, 4'd6}, // R6 operand + exc
    '{2'b11, 2'b01, 2'b10, 16'h0100, 16'h0100, 16'h0100, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 2'b01, 1'b1, 16'h0100, 1'b1, 4'd9}, // R9 pre beside post
    '{2'b11, 2'b01, 2'b01, 16'h0100, 16'h0100, 16'h0100, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 2'b11, 1'b1, 16'h0100, 1'b1, 4'd9}, // R9 pre beside pre
    '{2'b10, 2'b01, 2'b00, 16'h0100, 16'h0200, 16'h0100, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 2'b00, 1'b0, 16'h0000, 1'b0, 4'd11}, // R11 enable low
    '{2'b11, 2'b00, 2'b00, 16'h0100, 16'h0200, 16'h0100, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 2'b00, 1'b0, 16'h0000, 1'b0, 4'd11}, // R11 mode off
    '{2'b11, 2'b10, 2'b00, 16'h0100, 16'h0200, 16'h0104, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 2'b00, 1'b0, 16'h0000, 1'b0, 4'd2}  // R2 address mismatch
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NCH-1:0]    ch_en = '0;
  logic [2*NCH-1:0]  ch_mode = '0;
  logic [NCH*AW-1:0] ch_addr = '0;
  logic              cm_valid = 1'b0, cm_squash = 1'b0, cm_exc = 1'b0;
  logic              cm_dbranch = 1'b0, cm_dslot = 1'b0, cm_taken = 1'b0;
  logic              cm_opacc = 1'b0, cm_multi = 1'b0;
  logic [AW-1:0]     cm_pc = '0, cm_target = '0, cm_opaddr = '0;
  logic              flag_we = 1'b0, brk_ack = 1'b0;
  logic [NCH-1:0]    flag_wdata = '0;
  logic [NCH-1:0]    match_flags;
  logic              brk_req, brk_suppress;
  logic [AW-1:0]     brk_pc;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dbg_break_unit #(.AW(AW), .NCH(NCH), .INSN_BYTES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .ch_mode(ch_mode), .ch_addr(ch_addr),
    .cm_valid(cm_valid), .cm_squash(cm_squash), .cm_pc(cm_pc), .cm_exc(cm_exc),
    .cm_dbranch(cm_dbranch), .cm_dslot(cm_dslot), .cm_taken(cm_taken),
    .cm_target(cm_target), .cm_opacc(cm_opacc), .cm_opaddr(cm_opaddr),
    .cm_multi(cm_multi), .flag_we(flag_we), .flag_wdata(flag_wdata),
    .brk_ack(brk_ack), .match_flags(match_flags), .brk_req(brk_req),
    .brk_pc(brk_pc), .brk_suppress(brk_suppress)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    cm_valid = 1'b0; cm_squash = 1'b0; cm_exc = 1'b0; cm_dbranch = 1'b0;
    cm_dslot = 1'b0; cm_taken = 1'b0; cm_opacc = 1'b0; cm_multi = 1'b0;
    cm_pc = '0; cm_target = '0; cm_opaddr = '0;
  endtask

  task automatic ack_clear();
    brk_ack = 1'b1; flag_we = 1'b1; flag_wdata = '0;
    @(negedge clk);
    brk_ack = 1'b0; flag_we = 1'b0;
  endtask

  task automatic slot(input logic [15:0] pc, input logic br, input logic ds,
                      input logic tk, input logic [15:0] tgt);
    cm_valid = 1'b1; cm_pc = pc; cm_dbranch = br; cm_dslot = ds;
    cm_taken = tk; cm_target = tgt;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%h expected=%h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(match_flags == 2'b00, "R12", "flags in reset", 32'(match_flags), 0);
    chk(brk_req == 1'b0 && brk_suppress == 1'b0, "R12", "req/suppress in reset",
        32'({brk_req, brk_suppress}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      string rs;
      rs = $sformatf("R%0d", TBL[v].rq);
      ch_en = TBL[v].en; ch_mode = {TBL[v].m1, TBL[v].m0};
      ch_addr = {TBL[v].a1, TBL[v].a0};
      cm_valid = 1'b1; cm_pc = TBL[v].pc; cm_exc = TBL[v].exc; cm_squash = TBL[v].sq;
      cm_opacc = TBL[v].opacc; cm_opaddr = TBL[v].opaddr; cm_multi = TBL[v].multi;
      #1;
      chk(brk_suppress == TBL[v].es, rs, $sformatf("vec %0d suppress", v),
          32'(brk_suppress), 32'(TBL[v].es));
      @(negedge clk);
      idle();
      chk(match_flags == TBL[v].ef, rs, $sformatf("vec %0d flags", v),
          32'(match_flags), 32'(TBL[v].ef));
      chk(brk_req == TBL[v].er, rs, $sformatf("vec %0d req", v),
          32'(brk_req), 32'(TBL[v].er));
      if (TBL[v].er)
        chk(brk_pc == TBL[v].epc, rs, $sformatf("vec %0d pc", v),
            32'(brk_pc), 32'(TBL[v].epc));
      @(negedge clk);
      // R13: one-cycle pulse
      chk(brk_req == 1'b0, "R13", $sformatf("vec %0d pulse width", v), 32'(brk_req), 0);
      ack_clear();
    end

    // R3: post break on a taken delayed branch
    ch_en = 2'b11; ch_mode = {2'b00, 2'b10}; ch_addr = {16'h0000, 16'h0400};
    slot(16'h0400, 1'b1, 1'b0, 1'b1, 16'h0800);
    @(negedge clk); idle();
    chk(match_flags == 2'b01, "R3", "flag at taken branch", 32'(match_flags), 1);
    chk(brk_req == 1'b0, "R3", "no request before delay slot", 32'(brk_req), 0);
    slot(16'h0402, 1'b0, 1'b1, 1'b0, 16'h0000);
    @(negedge clk); idle();
    chk(brk_req == 1'b1, "R3", "request after delay slot", 32'(brk_req), 1);
    chk(brk_pc == 16'h0800, "R3", "pc = target", 32'(brk_pc), 32'h0800);
    ack_clear();

    // R3: not-taken delayed branch
    slot(16'h0400, 1'b1, 1'b0, 1'b0, 16'h0800);
    @(negedge clk);
    slot(16'h0402, 1'b0, 1'b1, 1'b0, 16'h0000);
    @(negedge clk); idle();
    chk(brk_req == 1'b1 && brk_pc == 16'h0404, "R3", "not taken pc", 32'(brk_pc), 32'h0404);
    ack_clear();

    // R4: post hit on the delay slot of a taken branch
    ch_mode = {2'b10, 2'b00}; ch_addr = {16'h0502, 16'h0000};
    slot(16'h0500, 1'b1, 1'b0, 1'b1, 16'h0900);
    @(negedge clk);
    slot(16'h0502, 1'b0, 1'b1, 1'b0, 16'h0000);
    @(negedge clk); idle();
    chk(brk_req == 1'b1 && brk_pc == 16'h0900, "R4", "delay slot resume pc",
        32'(brk_pc), 32'h0900);
    chk(match_flags == 2'b10, "R4", "delay slot flag", 32'(match_flags), 2);
    ack_clear();

    // R8: masked until acknowledge
    ch_mode = {2'b01, 2'b10}; ch_addr = {16'h0200, 16'h0100};
    slot(16'h0100, 1'b0, 1'b0, 1'b0, 16'h0000);
    @(negedge clk); idle();
    @(negedge clk);
    slot(16'h0200, 1'b0, 1'b0, 1'b0, 16'h0000);
    #1;
    chk(brk_suppress == 1'b0, "R8", "no suppress while waiting", 32'(brk_suppress), 0);
    @(negedge clk); idle();
    chk(match_flags == 2'b01, "R8", "no flag while waiting", 32'(match_flags), 1);
    chk(brk_req == 1'b0, "R8", "no request while waiting", 32'(brk_req), 0);
    brk_ack = 1'b1;
    @(negedge clk); brk_ack = 1'b0;
    slot(16'h0200, 1'b0, 1'b0, 1'b0, 16'h0000);
    @(negedge clk); idle();
    chk(brk_req == 1'b1 && brk_pc == 16'h0200, "R8", "request after ack",
        32'(brk_pc), 32'h0200);
    chk(match_flags == 2'b11, "R8", "flag after ack", 32'(match_flags), 3);
    @(negedge clk);

    // R10: selective clear and set-wins
    flag_we = 1'b1; flag_wdata = 2'b10; brk_ack = 1'b1;
    @(negedge clk); flag_we = 1'b0; brk_ack = 1'b0;
    chk(match_flags == 2'b10, "R10", "clear by zero bit", 32'(match_flags), 2);
    @(negedge clk);
    chk(match_flags == 2'b10, "R10", "flags sticky", 32'(match_flags), 2);
    flag_we = 1'b1; flag_wdata = 2'b00;
    slot(16'h0100, 1'b0, 1'b0, 1'b0, 16'h0000);
    @(negedge clk); idle(); flag_we = 1'b0;
    chk(match_flags == 2'b01, "R10", "set wins over clear", 32'(match_flags), 1);
    chk(brk_req == 1'b1 && brk_pc == 16'h0102, "R2", "post pc with clear",
        32'(brk_pc), 32'h0102);
    ack_clear();

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule